// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block is the timekeeping core of a real-time clock. It holds seconds, minutes, hours, date, month, day of week and a two-digit year, each as one byte of packed BCD. A single-cycle enable that arrives once per second advances the time by one second. The carry runs through every field, so the block handles month lengths, leap years, weekday wrap and the century wrap of the year without outside help.

A host interface sits in front of the block and uses a parallel port. It writes one register per cycle and reads any register combinationally. The seconds register carries a halt flag in its top bit, and this flag freezes all counting. The hours register carries a 12/24-hour mode bit in its top bit. In 12-hour mode bit 5 of the hours register is the PM flag. In 24-hour mode bit 5 is the upper tens-of-hours bit. The rollover logic handles both encodings.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the registers read seconds 0x00, minutes 0x00, hours 0x00 (24-hour mode), date 0x01, month 0x01, day-of-week 0x01 and year 0x00.
- R2: A write stores all 8 bits at the register index given (0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day-of-week, 6 year). Reads of that index return the stored value combinationally. Index 7 reads 0x00 and writes to index 7 are ignored.
- R3: Each accepted tick advances seconds (bits 6:0). Seconds wrap from 59 to 00 and carry into minutes. Minutes (bits 6:0) wrap from 59 to 00 and carry into hours.
- R4: While seconds bit 7 is 1, ticks change no register. Writing seconds with bit 7 at 0 lets the next tick count again.
- R5: With hours bit 7 at 0 (24-hour mode), hours in bits 5:0 run 00 to 23. The step from 23 to 00 advances the date and the day of week.
- R6: With hours bit 7 at 1 (12-hour mode), hours in bits 4:0 step from 11 to 12 and toggle bit 5 (1 = PM), then step from 12 to 01. The step from PM 11 to AM 12 advances the date and the day of week.
- R7: Date wraps to 01 after the last day of the current month (30 for April, June, September and November, 31 for the other long months) and advances the month. Month wraps from 12 to 01 and advances the year. Year wraps from 99 to 00.
- R8: February ends on day 29 when the BCD year is divisible by 4 (00 included), and on day 28 otherwise.
- R9: Day of week (bits 2:0) cycles 1 through 7 and returns to 1.
- R10: A write wins over a tick in the same cycle. If the write targets any register except seconds, the tick is held and applied in the next cycle. If the write targets seconds, the tick is dropped.
- R11: Rollovers leave bits outside the counted field unchanged, including the halt bit and the 12/24 mode bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | 3 | Write register index |
| wr_data_i | input | 8 | Write data |
| rd_idx_i | input | 3 | Read register index |
| rd_data_o | output | 8 | Read data (combinational) |

## Verification
The hardest states to reach through the ports are the deep cascades, such as 11:59:59 PM on 31 December of year 99, or 23:59:59 on the last day of February. Reaching them by ticking would take far too long. The stimulus therefore writes every register directly to one or two seconds before the boundary and then ticks across it. The held tick is another hard case, because it needs a tick and a write to coincide on the same edge. The bench drives both in one cycle and then compares the next cycle against a model that keeps its own pending flag.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
    localparam int REG_W    = 8;
    localparam int NUM_REGS = 7;
    localparam int IDX_W    = $clog2(NUM_REGS + 1);

    typedef enum logic [IDX_W-1:0] {
        IDX_SEC   = 3'd0,
        IDX_MIN   = 3'd1,
        IDX_HOUR  = 3'd2,
        IDX_DATE  = 3'd3,
        IDX_MONTH = 3'd4,
        IDX_DOW   = 3'd5,
        IDX_YEAR  = 3'd6
    } reg_idx_e;

    typedef struct packed {
        logic [REG_W-1:0] sec;
        logic [REG_W-1:0] min;
        logic [REG_W-1:0] hour;
        logic [REG_W-1:0] date;
        logic [REG_W-1:0] month;
        logic [REG_W-1:0] dow;
        logic [REG_W-1:0] year;
        logic             pend;
    } cal_state_t;

    function automatic logic [REG_W-1:0] pick_reg(cal_state_t s, logic [IDX_W-1:0] i);
        case (i)
            IDX_SEC:   return s.sec;
            IDX_MIN:   return s.min;
            IDX_HOUR:  return s.hour;
            IDX_DATE:  return s.date;
            IDX_MONTH: return s.month;
            IDX_DOW:   return s.dow;
            IDX_YEAR:  return s.year;
            default:   return '0;
        endcase
    endfunction
endpackage

// File: rtl/rtc_bcd_step.sv
module rtc_bcd_step #(
    parameter int         W  = 8,
    parameter logic [7:0] LO = 8'h00
) (
    input  logic [W-1:0] val_i,
    input  logic [W-1:0] max_i,
    output logic [W-1:0] next_o,
    output logic         wrap_o
);
    localparam int DIGITS = W / 4;

    logic carry;

    always_comb begin
        wrap_o = (val_i >= max_i);
        next_o = val_i;
        carry  = 1'b1;
        for (int i = 0; i < DIGITS; i++) begin
            if (carry) begin
                if (val_i[i*4 +: 4] >= 4'd9) begin
                    next_o[i*4 +: 4] = 4'd0;
                end else begin
                    next_o[i*4 +: 4] = val_i[i*4 +: 4] + 4'd1;
                    carry            = 1'b0;
                end
            end
        end
        if (wrap_o) begin
            next_o = LO[W-1:0];
        end
    end
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len (
    input  logic [4:0] month_i,
    input  logic [7:0] year_i,
    output logic [5:0] last_o
);
    logic [4:0] mod_sum;
    logic       leap;

    // 10*t + u is divisible by 4 exactly when 2*t + u is
    assign mod_sum = {year_i[7:4], 1'b0} + {1'b0, year_i[3:0]};
    assign leap    = (mod_sum[1:0] == 2'b00);

    always_comb begin
        case (month_i)
            5'h02:                      last_o = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_o = 6'h30;
            default:                    last_o = 6'h31;
        endcase
    end
endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step (
    input  logic [7:0] hour_i,
    output logic [7:0] next_o,
    output logic       day_o
);
    logic       mode12;
    logic       pm;
    logic [4:0] h12;
    logic [5:0] h24;

    assign mode12 = hour_i[7];
    assign pm     = hour_i[5];
    assign h12    = hour_i[4:0];
    assign h24    = hour_i[5:0];

    always_comb begin
        next_o = hour_i;
        day_o  = 1'b0;
        if (mode12) begin
            if (h12 == 5'h11) begin
                next_o = {hour_i[7:6], ~pm, 5'h12};
                day_o  = pm;
            end else if (h12 >= 5'h12) begin
                next_o = {hour_i[7:6], pm, 5'h01};
            end else if (h12[3:0] == 4'd9) begin
                next_o = {hour_i[7:6], pm, 1'b1, 4'h0};
            end else begin
                next_o = {hour_i[7:6], pm, h12[4], h12[3:0] + 4'd1};
            end
        end else begin
            if (h24 >= 6'h23) begin
                next_o = {hour_i[7:6], 6'h00};
                day_o  = 1'b1;
            end else if (h24[3:0] == 4'd9) begin
                next_o = {hour_i[7:6], h24[5:4] + 2'd1, 4'h0};
            end else begin
                next_o = {hour_i[7:6], h24[5:4], h24[3:0] + 4'd1};
            end
        end
    end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [REG_W-1:0] rd_data_o
);
    cal_state_t st_q, st_d;

    logic       wr_hit, act, go, adv;
    logic [7:0] sec_nx, min_nx, hour_nx, date_nx, month_nx, dow_nx, year_nx;
    logic       sec_wrap, min_wrap, day_wrap, date_wrap, month_wrap, dow_wrap, year_wrap;
    logic [5:0] last_day;

    assign wr_hit = wr_en_i && (wr_idx_i < IDX_W'(NUM_REGS));
    assign act    = tick_i | st_q.pend;
    assign go     = act & ~st_q.sec[7];
    assign adv    = go & ~wr_hit;

    rtc_bcd_step #(.W(8), .LO(8'h00)) u_sec (
        .val_i({1'b0, st_q.sec[6:0]}), .max_i(8'h59), .next_o(sec_nx), .wrap_o(sec_wrap));
    rtc_bcd_step #(.W(8), .LO(8'h00)) u_min (
        .val_i({1'b0, st_q.min[6:0]}), .max_i(8'h59), .next_o(min_nx), .wrap_o(min_wrap));
    rtc_hour_step u_hour (
        .hour_i(st_q.hour), .next_o(hour_nx), .day_o(day_wrap));
    rtc_month_len u_mlen (
        .month_i(st_q.month[4:0]), .year_i(st_q.year), .last_o(last_day));
    rtc_bcd_step #(.W(8), .LO(8'h01)) u_date (
        .val_i({2'b0, st_q.date[5:0]}), .max_i({2'b0, last_day}), .next_o(date_nx), .wrap_o(date_wrap));
    rtc_bcd_step #(.W(8), .LO(8'h01)) u_month (
        .val_i({3'b0, st_q.month[4:0]}), .max_i(8'h12), .next_o(month_nx), .wrap_o(month_wrap));
    rtc_bcd_step #(.W(8), .LO(8'h01)) u_dow (
        .val_i({5'b0, st_q.dow[2:0]}), .max_i(8'h07), .next_o(dow_nx), .wrap_o(dow_wrap));
    rtc_bcd_step #(.W(8), .LO(8'h00)) u_year (
        .val_i(st_q.year), .max_i(8'h99), .next_o(year_nx), .wrap_o(year_wrap));

    always_comb begin
        st_d      = st_q;
        st_d.pend = 1'b0;
        if (wr_hit) begin
            case (wr_idx_i)
                IDX_SEC:   st_d.sec   = wr_data_i;
                IDX_MIN:   st_d.min   = wr_data_i;
                IDX_HOUR:  st_d.hour  = wr_data_i;
                IDX_DATE:  st_d.date  = wr_data_i;
                IDX_MONTH: st_d.month = wr_data_i;
                IDX_DOW:   st_d.dow   = wr_data_i;
                default:   st_d.year  = wr_data_i;
            endcase
            st_d.pend = go && (wr_idx_i != IDX_SEC);
        end else if (adv) begin
            st_d.sec = {st_q.sec[7], sec_nx[6:0]};
            if (sec_wrap) begin
                st_d.min = {st_q.min[7], min_nx[6:0]};
                if (min_wrap) begin
                    st_d.hour = hour_nx;
                    if (day_wrap) begin
                        st_d.dow  = {st_q.dow[7:3], dow_nx[2:0]};
                        st_d.date = {st_q.date[7:6], date_nx[5:0]};
                        if (date_wrap) begin
                            st_d.month = {st_q.month[7:5], month_nx[4:0]};
                            if (month_wrap) begin
                                st_d.year = year_nx;
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{sec: 8'h00, min: 8'h00, hour: 8'h00, date: 8'h01,
                      month: 8'h01, dow: 8'h01, year: 8'h00, pend: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = pick_reg(st_q, rd_idx_i);

    // R4: a halted clock with no write keeps every time field still
    a_r4_halt_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.sec[7] && !wr_en_i) |=> ($stable(st_q.min) && $stable(st_q.hour) && $stable(st_q.sec)));

    // R10: the written value is what the register holds next cycle
    a_r10_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_hit |=> (pick_reg(st_q, $past(wr_idx_i)) == $past(wr_data_i)));

    // R10: a seconds write leaves no tick held
    a_r10_sec_write_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_hit && wr_idx_i == IDX_SEC) |=> !st_q.pend);

    // R3: seconds at 59 wrap to 00 on an advance
    a_r3_sec_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv && st_q.sec[6:0] == 7'h59) |=> (st_q.sec[6:0] == 7'h00));

    // R11: the mode bit only changes through a write to hours
    a_r11_mode_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_hit && wr_idx_i == IDX_HOUR) |=> $stable(st_q.hour[7]));
endmodule

// File: tb/rtc_calendar_core_tb.sv
`timescale 1ns/100ps
module rtc_calendar_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_idx = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_idx = '0;
    logic [7:0] rd_data;

    int tests = 0;
    int fails = 0;
    string cur_req = "R1";

    logic [7:0] m [7];
    bit         m_pend;

    always #2.5 clk = ~clk;

    rtc_calendar_core u_dut (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
        .wr_idx_i(wr_idx), .wr_data_i(wr_data), .rd_idx_i(rd_idx), .rd_data_o(rd_data));

    function automatic int b2i(logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] i2b(int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int days_in(int mon, int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    task automatic model_reset();
        m[0] = 8'h00; m[1] = 8'h00; m[2] = 8'h00; m[3] = 8'h01;
        m[4] = 8'h01; m[5] = 8'h01; m[6] = 8'h00; m_pend = 0;
    endtask

    task automatic model_advance();
        int s, mi, h, d, mo, w, y;
        bit pm, next_day;
        s = b2i({1'b0, m[0][6:0]});
        if (s < 59) begin m[0][6:0] = i2b(s + 1)[6:0]; return; end
        m[0][6:0] = 7'h00;
        mi = b2i({1'b0, m[1][6:0]});
        if (mi < 59) begin m[1][6:0] = i2b(mi + 1)[6:0]; return; end
        m[1][6:0] = 7'h00;
        next_day = 0;
        if (m[2][7]) begin
            h  = b2i({3'b0, m[2][4:0]});
            pm = m[2][5];
            if (h == 11) begin h = 12; next_day = pm; pm = !pm; end
            else if (h >= 12) h = 1;
            else h++;
            m[2][5]   = pm;
            m[2][4:0] = i2b(h)[4:0];
        end else begin
            h = b2i({2'b0, m[2][5:0]});
            if (h >= 23) begin h = 0; next_day = 1; end else h++;
            m[2][5:0] = i2b(h)[5:0];
        end
        if (!next_day) return;
        w = int'(m[5][2:0]);
        m[5][2:0] = (w >= 7) ? 3'd1 : 3'(w + 1);
        d  = b2i({2'b0, m[3][5:0]});
        mo = b2i({3'b0, m[4][4:0]});
        y  = b2i(m[6]);
        if (d < days_in(mo, y)) begin m[3][5:0] = i2b(d + 1)[5:0]; return; end
        m[3][5:0] = 6'h01;
        if (mo < 12) begin m[4][4:0] = i2b(mo + 1)[4:0]; return; end
        m[4][4:0] = 5'h01;
        m[6] = (y >= 99) ? 8'h00 : i2b(y + 1);
    endtask

    task automatic model_step(bit t, bit w, logic [2:0] a, logic [7:0] dat);
        bit go;
        go = (t || m_pend) && !m[0][7];
        if (w && a < 3'd7) begin
            m[a]   = dat;
            m_pend = go && (a != 3'd0);
        end else begin
            m_pend = 0;
            if (go) model_advance();
        end
    endtask

    task automatic compare_all();
        for (int a = 0; a < 7; a++) begin
            rd_idx = 3'(a);
            #0.1;
            tests++;
            if (rd_data !== m[a]) begin
                fails++;
                $display("FAIL %s reg %0d: actual %h expected %h at %0t", cur_req, a, rd_data, m[a], $time);
            end
        end
    endtask

    task automatic cyc(bit t, bit w, logic [2:0] a, logic [7:0] dat);
        tick = t; wr_en = w; wr_idx = a; wr_data = dat;
        @(posedge clk);
        model_step(t, w, a, dat);
        @(negedge clk);
        tick = 0; wr_en = 0;
        compare_all();
    endtask

    task automatic load(logic [7:0] s, logic [7:0] mi, logic [7:0] h, logic [7:0] d,
                        logic [7:0] mo, logic [7:0] w, logic [7:0] y);
        cyc(0, 1, 3'd6, y);  cyc(0, 1, 3'd4, mo); cyc(0, 1, 3'd3, d);
        cyc(0, 1, 3'd5, w);  cyc(0, 1, 3'd2, h);  cyc(0, 1, 3'd1, mi);
        cyc(0, 1, 3'd0, s);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) cyc(1, 0, 3'd0, 8'h00);
    endtask

    task automatic expect_reg(int a, logic [7:0] exp_v, string req);
        rd_idx = 3'(a);
        #0.1;
        tests++;
        if (rd_data !== exp_v) begin
            fails++;
            $display("FAIL %s reg %0d: actual %h expected %h", req, a, rd_data, exp_v);
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
        compare_all();
        expect_reg(3, 8'h01, "R1");

        cur_req = "R2 R10";
        cyc(1, 1, 3'd1, 8'h37);
        cyc(0, 0, 3'd0, 8'h00);
        cyc(1, 1, 3'd0, 8'h42);
        cyc(0, 0, 3'd0, 8'h00);
        expect_reg(0, 8'h42, "R10");
        cyc(0, 1, 3'd7, 8'hFF);
        expect_reg(7, 8'h00, "R2");

        cur_req = "R3 R5 R7 R9";
        load(8'h58, 8'h59, 8'h23, 8'h31, 8'h12, 8'h07, 8'h99);
        ticks(2);
        expect_reg(6, 8'h00, "R7");
        expect_reg(5, 8'h01, "R9");
        ticks(70);

        cur_req = "R6 R11";
        load(8'h59, 8'h59, 8'hD1, 8'h15, 8'h06, 8'h03, 8'h10);
        ticks(1);
        expect_reg(2, 8'hF2, "R6");
        load(8'h59, 8'h59, 8'hF1, 8'h30, 8'h06, 8'h03, 8'h10);
        ticks(1);
        expect_reg(2, 8'hD2, "R6");
        expect_reg(4, 8'h07, "R7");
        load(8'h59, 8'h59, 8'h92, 8'h30, 8'h06, 8'h03, 8'h10);
        ticks(1);
        expect_reg(2, 8'h81, "R6");
        load(8'h59, 8'h59, 8'h89, 8'h02, 8'h06, 8'h03, 8'h10);
        ticks(1);
        expect_reg(2, 8'h90, "R6");

        cur_req = "R8";
        load(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h02, 8'h24);
        ticks(1);
        expect_reg(3, 8'h29, "R8");
        load(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h02, 8'h23);
        ticks(1);
        expect_reg(4, 8'h03, "R8");
        load(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h02, 8'h00);
        ticks(1);
        expect_reg(3, 8'h29, "R8");
        cur_req = "R7";
        load(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h02, 8'h05);
        ticks(1);
        expect_reg(4, 8'h05, "R7");

        cur_req = "R4 R11";
        load(8'h85, 8'h10, 8'h05, 8'h10, 8'h05, 8'h04, 8'h05);
        ticks(5);
        expect_reg(0, 8'h85, "R4");
        cyc(0, 1, 3'd0, 8'h05);
        ticks(3);
        expect_reg(0, 8'h08, "R4");
        load(8'hD9, 8'h59, 8'h23, 8'h10, 8'h05, 8'h04, 8'h05);
        ticks(2);
        expect_reg(0, 8'hD9, "R4");

        cur_req = "R10";
        load(8'h10, 8'h20, 8'h05, 8'h10, 8'h05, 8'h04, 8'h05);
        cyc(1, 1, 3'd1, 8'h33);
        cyc(0, 0, 3'd0, 8'h00);
        expect_reg(0, 8'h11, "R10");
        cyc(1, 1, 3'd0, 8'h20);
        cyc(0, 0, 3'd0, 8'h00);
        expect_reg(0, 8'h20, "R10");
        for (int i = 0; i < 40; i++) cyc(i % 3 == 0, i % 5 == 0, 3'(i % 7), 8'h12);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule